// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

This block is a 16-bit down-counting timer behind a small byte-wide register port. Software writes a 16-bit start value as two separate bytes, chooses a count source, and starts the counter. The source is either a prescaled system clock (divide by 4, 16, 64 or 256) or rising edges on an external event pin. The event pin passes through a synchronizer and a short delay line, so each pin edge takes effect a fixed, known number of clocks later.

The counter either stops at zero after one pass or reloads itself and keeps running. A control bit forces a reload on the next clock edge, which also restarts the prescaler phase. The two count byte addresses are shared with the reload bytes: a write sets the reload value, and a read returns the live count. Reading the low byte captures the high byte, so a two-step 16-bit read sees one consistent value. At terminal count a sticky flag is set. The interrupt output is that flag gated by an enable bit.

Top module: `reload_timer`

## Requirements
- R1: The reload value is {byte written at address 3, byte written at address 2}; bit 7 of the address-3 byte is reload bit 15 and its bit 0 is reload bit 8. Both reload bytes reset to 0x00.
- R2: The reload bytes are write-only. A read at address 2 returns count[7:0], never the reload byte.
- R3: A write to the control register (address 0) with bit 1 set is captured at clock edge N, and the count equals the reload value after edge N+1. Control bit 1 always reads back 0.
- R4: With control bit 5 = 0 and run (bit 0) = 1, the count drops by one every D clocks, where D = 4, 16, 64 or 256 for control bits [4:3] = 0, 1, 2 or 3. The first drop comes D edges after the reload edge.
- R5: With control bit 5 = 1, the count drops once for each rising edge of ev_pin, on the fifth rising clock edge after the pin edge. A pin held high causes no further drops.
- R6: In continuous mode (control bit 2 = 1), a count tick while the count is 1 or 0 loads the reload value again.
- R7: In single-pass mode (control bit 2 = 0), a count tick while the count is 1 or 0 leaves the count at 0 and clears run (control bit 0 reads 0). Later time leaves the count at 0.
- R8: A terminal tick sets a sticky flag, read as status bit 0 at address 1. Any read at address 0 or 1 clears it at that clock edge.
- R9: irq_o is high exactly when the flag is set and control bit 6 (interrupt enable) is 1.
- R10: A read at address 2 captures count[15:8]. A later read at address 3 returns the captured byte, so the two reads form one snapshot.
- R11: With run = 0 and no restart, the count holds its value.
- R12: After reset, the count, control, flag and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address (0 control, 1 status, 2 count/reload low, 3 count/reload high) |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle; read side effects happen at the clock edge |
| rd_data | output | 8 | Read data for addr, combinational |
| ev_pin | input | 1 | External event pin, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is driven with random reload values, divider settings and run modes, and sampled after random delays. A bench model predicts each sample, so phase errors in the prescaler and wrong reload-on-terminal behaviour both show up as byte mismatches. The low and high reads of each sample are checked separately, which separates a broken byte snapshot from a wrong count. Directed cases do the following:
- probe the exact edge of the first prescaled decrement, and the exact fifth-clock edge of an event decrement;
- hold the event pin high, to show that a level does not count;
- run a single pass to zero, to show that run is cleared;
- raise the flag with the interrupt disabled and then enabled, to separate the flag from irq_o.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_STAT   = 2'd1,
    RA_CNT_LO = 2'd2,
    RA_CNT_HI = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_RESTART = 1;
  localparam int unsigned CB_CONT    = 2;
  localparam int unsigned CB_DIV_LO  = 3;
  localparam int unsigned CB_SRC_EV  = 5;
  localparam int unsigned CB_IRQ_EN  = 6;

  // divide ratio selected by the two-bit divider field: 4, 16, 64, 256
  function automatic int unsigned prescale_div(input logic [1:0] sel);
    return 32'd4 << (2 * sel);
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler
  import rt_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  assign mask = PRE_W'(prescale_div(sel) - 1);
  assign tick = en && ((phase_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr)    phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else if (en)     phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rt_event_sync.sv
module rt_event_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LATENCY     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic tick
);
  // one stage for the edge history, the rest pad out to the total latency
  localparam int unsigned DLY = LATENCY - SYNC_STAGES - 1;

  logic [SYNC_STAGES:0] shift_q;
  logic [DLY-1:0]       dly_q;
  logic                 rise;

  assign rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      dly_q   <= '0;
    end else begin
      shift_q <= {shift_q[SYNC_STAGES-1:0], pin};
      dly_q[0] <= rise;
      for (int i = 1; i < DLY; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assign tick = dly_q[DLY-1];
endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             cont,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             term_evt
);
  function automatic logic at_terminal(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  assign term_evt = tick && !load && at_terminal(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load)     count <= reload;
    else if (term_evt) count <= cont ? reload : '0;
    else if (tick)     count <= count - 1'b1;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int unsigned DATA_W     = BYTE_W,
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned EV_LATENCY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_pin,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic              run_q, cont_q, src_ev_q, irq_en_q;
  logic [1:0]        div_sel_q;
  logic              restart_pend;
  logic [DATA_W-1:0] reload_lo_q, reload_hi_q, hi_snap_q;
  logic              eoc_flag;
  logic [CNT_W-1:0]  reload_val, count;

  // named internal events
  logic ctrl_wr, flag_clr_rd, pre_tick, ev_tick, tick, term_evt, pre_en;
  wire  unused_wbits = ^wr_data[DATA_W-1:CB_IRQ_EN+1];

  assign ctrl_wr     = wr_en && (addr == RA_CTRL);
  assign flag_clr_rd = rd_en && ((addr == RA_CTRL) || (addr == RA_STAT));
  assign reload_val  = {reload_hi_q, reload_lo_q};
  assign pre_en      = run_q && !src_ev_q && !restart_pend;
  assign tick        = run_q && (src_ev_q ? ev_tick : pre_tick);
  assign irq_o       = eoc_flag & irq_en_q;

  rt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(pre_en), .clr(restart_pend),
    .sel(div_sel_q), .tick(pre_tick)
  );

  rt_event_sync #(.SYNC_STAGES(2), .LATENCY(EV_LATENCY)) evs_i (
    .clk(clk), .rst_n(rst_n), .pin(ev_pin), .tick(ev_tick)
  );

  rt_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(restart_pend),
    .cont(cont_q), .reload(reload_val), .count(count), .term_evt(term_evt)
  );

  // control register and restart request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      cont_q       <= 1'b0;
      src_ev_q     <= 1'b0;
      irq_en_q     <= 1'b0;
      div_sel_q    <= '0;
      restart_pend <= 1'b0;
    end else begin
      restart_pend <= ctrl_wr && wr_data[CB_RESTART];
      if (term_evt && !cont_q) run_q <= 1'b0;
      if (ctrl_wr) begin
        run_q     <= wr_data[CB_RUN];
        cont_q    <= wr_data[CB_CONT];
        div_sel_q <= wr_data[CB_DIV_LO +: 2];
        src_ev_q  <= wr_data[CB_SRC_EV];
        irq_en_q  <= wr_data[CB_IRQ_EN];
      end
    end
  end

  // reload bytes (write side of the shared count addresses)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_lo_q <= '0;
      reload_hi_q <= '0;
    end else if (wr_en) begin
      if (addr == RA_CNT_LO) reload_lo_q <= wr_data;
      if (addr == RA_CNT_HI) reload_hi_q <= wr_data;
    end
  end

  // sticky end-of-count flag and the high-byte snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_flag  <= 1'b0;
      hi_snap_q <= '0;
    end else begin
      if (term_evt)         eoc_flag <= 1'b1;
      else if (flag_clr_rd) eoc_flag <= 1'b0;
      if (rd_en && (addr == RA_CNT_LO)) hi_snap_q <= count[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      RA_CTRL: begin
        rd_data[CB_RUN]          = run_q;
        rd_data[CB_CONT]         = cont_q;
        rd_data[CB_DIV_LO +: 2]  = div_sel_q;
        rd_data[CB_SRC_EV]       = src_ev_q;
        rd_data[CB_IRQ_EN]       = irq_en_q;
      end
      RA_STAT:   rd_data[0] = eoc_flag;
      RA_CNT_LO: rd_data    = count[DATA_W-1:0];
      RA_CNT_HI: rd_data    = hi_snap_q;
      default:   rd_data    = '0;
    endcase
  end
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_pin,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val,
  input logic             restart_pend,
  input logic             tick,
  input logic             ev_tick,
  input logic             term_evt,
  input logic             cont_q,
  input logic             run_q,
  input logic             ctrl_wr,
  input logic             eoc_flag,
  input logic             flag_clr_rd,
  input logic             irq_o
);
  a_r3_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pend |=> count == $past(reload_val));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart_pend && count > CNT_W'(1)) |=> count == $past(count) - 1'b1);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart_pend) |=> $stable(count));

  a_r5_event_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tick |-> ($past(ev_pin, 4) && !$past(ev_pin, 5)));

  a_r6_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && cont_q) |=> count == $past(reload_val));

  a_r7_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && !cont_q && !ctrl_wr) |=> (count == '0 && !run_q));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> eoc_flag);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_rd && !term_evt) |=> !eoc_flag);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> eoc_flag);
endmodule

bind reload_timer rt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_pin(ev_pin), .count(count),
  .reload_val(reload_val), .restart_pend(restart_pend), .tick(tick),
  .ev_tick(ev_tick), .term_evt(term_evt), .cont_q(cont_q), .run_q(run_q),
  .ctrl_wr(ctrl_wr), .eoc_flag(eoc_flag), .flag_clr_rd(flag_clr_rd),
  .irq_o(irq_o)
);

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       ev_pin = 1'b0;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ev_pin(ev_pin), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // bench model of the count after k edges following a reload edge
  function automatic int model_count(input int rl, input int dv, input int k, input bit cont);
    int c = rl;
    for (int i = 1; i <= k; i++) begin
      if (i % dv == 0) begin
        if (c <= 1) c = cont ? rl : 0;
        else        c = c - 1;
      end
    end
    return c;
  endfunction

  function automatic int div_of(input int sel);
    return 4 << (2 * sel);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int load_c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq after reset", irq_o, 0);
    rd(2'd0, v); chk("R12 ctrl after reset", v, 8'h00);
    rd(2'd1, v); chk("R12 status after reset", v, 8'h00);
    rd(2'd2, v); chk("R12 count lo after reset", v, 8'h00);
    rd(2'd3, v); chk("R12 count hi after reset", v, 8'h00);

    // R1 R2 R3 R10 R11: reload bytes, write-only, restart timing
    wr(2'd2, 8'h34); wr(2'd3, 8'h12);
    rd(2'd2, v); chk("R2 read returns count not reload", v, 8'h00);
    wr(2'd0, 8'h02);
    rd(2'd2, v); chk("R3 no load at write edge", v, 8'h00);
    rd(2'd2, v); chk("R1 reload low byte", v, 8'h34);
    rd(2'd3, v); chk("R1 R10 reload high byte via snapshot", v, 8'h12);
    rd(2'd0, v); chk("R3 restart bit reads zero", v, 8'h00);
    repeat (50) @(negedge clk);
    rd(2'd2, v); chk("R11 count held while stopped", v, 8'h34);

    // R4 exact first decrement edge, divide by 16
    wr(2'd2, 8'd100); wr(2'd3, 8'd0);
    wr(2'd0, 8'h0B);
    load_c = cyc + 1;
    wait_until(load_c + 15);
    rd(2'd2, v); chk("R4 before first /16 step", v, 100);
    rd(2'd2, v); chk("R4 at first /16 step", v, 99);
    wr(2'd0, 8'h00);

    // R5 event source: decrement on fifth edge, one per rise
    wr(2'd0, 8'h27);
    repeat (3) @(negedge clk);
    ev_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R5 count after fourth edge", v, 100);
    rd(2'd2, v); chk("R5 count after fifth edge", v, 99);
    repeat (12) @(negedge clk);
    rd(2'd2, v); chk("R5 held level gives one step", v, 99);
    ev_pin = 1'b0;
    repeat (5) @(negedge clk);
    ev_pin = 1'b1;
    repeat (8) @(negedge clk);
    rd(2'd2, v); chk("R5 second rise second step", v, 98);
    ev_pin = 1'b0;
    wr(2'd0, 8'h00);

    // R7 R8 R9 single pass to zero
    wr(2'd2, 8'd3);
    rd(2'd1, v);
    wr(2'd0, 8'h43);
    load_c = cyc + 1;
    wait_until(load_c + 20);
    chk("R9 irq with flag and enable", irq_o, 1);
    rd(2'd1, v); chk("R8 flag set at terminal", v, 8'h01);
    chk("R8 R9 irq drops after status read", irq_o, 0);
    rd(2'd1, v); chk("R8 flag cleared by read", v, 8'h00);
    rd(2'd0, v); chk("R7 run cleared after single pass", v, 8'h40);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R7 count stays zero", v, 8'h00);

    // R6 R9 continuous with interrupt masked then enabled
    wr(2'd2, 8'd2);
    wr(2'd0, 8'h07);
    load_c = cyc + 1;
    wait_until(load_c + 9);
    chk("R9 irq masked while flag set", irq_o, 0);
    wr(2'd0, 8'h45);
    chk("R9 irq once enabled", irq_o, 1);
    rd(2'd1, v); chk("R6 flag from continuous terminal", v, 8'h01);
    rd(2'd2, v);
    chk("R6 continuous count", v, model_count(2, 4, cyc - 1 - load_c, 1'b1) & 8'hFF);
    wr(2'd0, 8'h00);

    // R4 R6 R7 R10 random reload, divider, mode and sample time
    for (int it = 0; it < 24; it++) begin
      int rl, sel, cm, w, k, e;
      rl  = $urandom_range(0, 700);
      sel = $urandom_range(0, 3);
      cm  = $urandom_range(0, 1);
      w   = $urandom_range(0, 900);
      wr(2'd2, 8'(rl)); wr(2'd3, 8'(rl >> 8));
      wr(2'd0, 8'(8'h03 | (cm << 2) | (sel << 3)));
      load_c = cyc + 1;
      wait_until(load_c + 1 + w);
      k = cyc - load_c;
      e = model_count(rl, div_of(sel), k, cm[0]);
      rd(2'd2, v); chk("R4 R6 R7 random count low", v, e & 8'hFF);
      rd(2'd3, v); chk("R10 random count high snapshot", v, (e >> 8) & 8'hFF);
      wr(2'd0, 8'h00);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule